// File: doc/BRIEF.md
# Compare-Channel Timer

This block is a timer peripheral sitting on a 32-bit register bus. It holds an up-counter of parameterized width, a power-of-two clock prescaler, a modulo limit and a single compare channel. Software enables counting through a clock-select field and picks the division ratio. The counter runs from zero up to the modulo value and then returns to zero, raising a sticky overflow flag as it does. A read-only register reports the counter width, so that driver code can find out whether the counter is 16 or 32 bits wide.

The channel in software-compare mode raises its flag when the counter steps onto the programmed compare value. The interrupt pin is the channel flag gated by the channel's interrupt enable. Both flags are cleared by writing a one, and the channel flag can be cleared from either of the two registers that show it. A write of any value to the counter register forces the counter to zero.

Every bus access completes in the cycle in which `bus_valid` is high. The bus has no ready signal and applies no back-pressure. Read data is combinational from `bus_addr`, and a read has no side effects.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 0, the modulo register reads all ones for the counter width, both control registers and the status register read 0, and `irq` is low. The read-only register at 0x04 returns the counter width in bits [23:16]: 0x10 for 16 bits and 0x20 for 32 bits.
- R2: The counter advances only when the clock-select field (bits [4:3] of the control register at 0x10) is 2'b01. With any other value, the counter holds its value.
- R3: The prescale field (bits [2:0] of the control register) makes the counter step once every 2^N bus clock cycles. The first step comes 2^N cycles after the write that enables counting.
- R4: On a step taken while the counter equals the modulo register (0x18), the counter goes to 0. With the modulo register at all ones, the counter runs freely through its full range.
- R5: The overflow flag (bit 7 of the control register) is set by the step that wraps the counter to 0. Writing a 1 to that bit clears the flag. Writing a 0 to it leaves the flag unchanged.
- R6: A write of any data to the counter register (0x14) sets the counter to 0 at that clock edge. This write takes priority over a step in the same cycle.
- R7: When the channel mode field (bits [5:2] of 0x20) is 4, the channel flag sets on the step that moves the counter onto the compare value (0x24). In any other mode the channel flag never sets.
- R8: The channel flag is visible both as bit 7 of 0x20 and as bit 0 of the status register at 0x1C. Writing a 1 to either of those bits clears it.
- R9: `irq` is high exactly when the channel flag is set and the channel interrupt enable (bit 6 of 0x20) is 1.
- R10: When a compare match and a software clear of the channel flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Channel interrupt request |

## Verification
The main sweep crosses prescale settings 0 to 3 with two modulo limits and two compare positions. One compare position is the first count and the other is the modulo value itself. The counter is read after every clock, which separates an off-by-one in the division ratio from an off-by-one in the wrap point. It also catches a flag that sets one step early or one step late.

Separate patterns cover the following:
- a stopped counter under two non-counting clock selects;
- a full free-running wrap at the counter width;
- a non-compare channel mode;
- clearing each flag with a one, and writing a zero that must leave the flag alone;
- a match and a software clear aligned to the same edge, which shows whether set wins over clear.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam logic [7:0] OFF_PARAM  = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h10;
  localparam logic [7:0] OFF_COUNT  = 8'h14;
  localparam logic [7:0] OFF_MOD    = 8'h18;
  localparam logic [7:0] OFF_STAT   = 8'h1C;
  localparam logic [7:0] OFF_CHCTRL = 8'h20;
  localparam logic [7:0] OFF_CHVAL  = 8'h24;

  localparam int PS_W = 3;

  localparam logic [1:0] CLK_SEL_INC = 2'b01;
  localparam logic [3:0] CH_MODE_SWCMP = 4'h4;

  typedef struct packed {
    logic [1:0]      clk_sel;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  typedef struct packed {
    logic       ie;
    logic [3:0] mode;
  } chctrl_t;
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = DIV_W'((32'd1 << ps) - 32'd1);
    tick = en && (div_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!en || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: for any division above one, two steps never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps != '0) |=> (!tick || ps == '0));

  // R2: a stopped prescaler produces no step
  p_no_tick_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] modv,
  input  logic             tof_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             adv,
  output logic             tof_q
);
  logic at_lim;
  logic wrap;

  always_comb begin
    at_lim = (cnt_q == modv) || (cnt_q == {CNT_W{1'b1}});
    adv    = tick && !clr;
    wrap   = adv && at_lim;
    if (clr)       cnt_nxt = '0;
    else if (!adv) cnt_nxt = cnt_q;
    else if (at_lim) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tof_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (wrap)         tof_q <= 1'b1;
      else if (tof_clr) tof_q <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt_q == modv) |=> cnt_q == '0);

  p_tof_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt_q == modv) |=> tof_q);

  p_tof_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tof_q && !tof_clr) |=> tof_q);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmpv,
  input  logic [3:0]       mode,
  input  logic             ie,
  input  logic             flag_clr,
  output logic             chf_q,
  output logic             irq
);
  import cmp_timer_pkg::*;

  logic hit;

  always_comb begin
    hit = adv && (mode == CH_MODE_SWCMP) && (cnt_nxt == cmpv);
    irq = chf_q && ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chf_q <= 1'b0;
    else if (hit)      chf_q <= 1'b1;
    else if (flag_clr) chf_q <= 1'b0;
  end

  p_match_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == CH_MODE_SWCMP && cnt_nxt == cmpv) |=> chf_q);

  p_other_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chf_q && mode != CH_MODE_SWCMP) |=> !chf_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !adv) |=> !chf_q);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && hit) |=> chf_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import cmp_timer_pkg::*;

  localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

  ctrl_t            ctrl_q;
  chctrl_t          chc_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cmp_q;

  logic             wr_en;
  logic             wr_ctrl, wr_count, wr_mod, wr_stat, wr_chctrl, wr_chval;
  logic             tick, adv, tof_q, chf_q, cnt_en, chf_clr;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    wr_en     = bus_valid && bus_write;
    wr_ctrl   = wr_en && (bus_addr == ADDR_W'(OFF_CTRL));
    wr_count  = wr_en && (bus_addr == ADDR_W'(OFF_COUNT));
    wr_mod    = wr_en && (bus_addr == ADDR_W'(OFF_MOD));
    wr_stat   = wr_en && (bus_addr == ADDR_W'(OFF_STAT));
    wr_chctrl = wr_en && (bus_addr == ADDR_W'(OFF_CHCTRL));
    wr_chval  = wr_en && (bus_addr == ADDR_W'(OFF_CHVAL));
    cnt_en    = (ctrl_q.clk_sel == CLK_SEL_INC);
    chf_clr   = (wr_chctrl && bus_wdata[7]) || (wr_stat && bus_wdata[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chc_q  <= '0;
      mod_q  <= {CNT_W{1'b1}};
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q <= ctrl_t'(bus_wdata[4:0]);
      if (wr_chctrl) chc_q  <= chctrl_t'(bus_wdata[6:2]);
      if (wr_mod)    mod_q  <= bus_wdata[CNT_W-1:0];
      if (wr_chval)  cmp_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  cmp_timer_presc #(.PS_W(PS_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .ps   (ctrl_q.ps),
    .tick (tick)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (wr_count),
    .modv   (mod_q),
    .tof_clr(wr_ctrl && bus_wdata[7]),
    .cnt_q  (cnt_q),
    .cnt_nxt(cnt_nxt),
    .adv    (adv),
    .tof_q  (tof_q)
  );

  cmp_timer_chan #(.CNT_W(CNT_W)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .cnt_nxt (cnt_nxt),
    .cmpv    (cmp_q),
    .mode    (chc_q.mode),
    .ie      (chc_q.ie),
    .flag_clr(chf_clr),
    .chf_q   (chf_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_PARAM):  bus_rdata = {8'h00, WIDTH_CODE, 16'h0000};
      ADDR_W'(OFF_CTRL):   bus_rdata = {24'd0, tof_q, 2'b00, ctrl_q};
      ADDR_W'(OFF_COUNT):  bus_rdata = 32'(cnt_q);
      ADDR_W'(OFF_MOD):    bus_rdata = 32'(mod_q);
      ADDR_W'(OFF_STAT):   bus_rdata = {31'd0, chf_q};
      ADDR_W'(OFF_CHCTRL): bus_rdata = {24'd0, chf_q, chc_q, 2'b00};
      ADDR_W'(OFF_CHVAL):  bus_rdata = 32'(cmp_q);
      default:             bus_rdata = '0;
    endcase
  end

  // R9: the interrupt pin follows the channel flag only while enabled
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chc_q.ie) |-> !irq);

  // R8: a clear written through the status register takes hold
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !tick) |=> !bus_rdata_flag_chk(chf_q));

  function automatic logic bus_rdata_flag_chk(input logic f);
    return f;
  endfunction
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_COUNT = 8'h14,
                         A_MOD = 8'h18, A_STAT = 8'h1C, A_CHCTRL = 8'h20,
                         A_CHVAL = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // drives one write through the next rising edge; caller sits just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got %h expected %h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_PARAM, d);  chk("R1 width", d, 32'h0010_0000);
    rd(A_COUNT, d);  chk("R1 count", d, 32'd0);
    rd(A_MOD, d);    chk("R1 modulo", d, 32'h0000_FFFF);
    rd(A_CTRL, d);   chk("R1 ctrl", d, 32'd0);
    rd(A_CHCTRL, d); chk("R1 chctrl", d, 32'd0);
    rd(A_STAT, d);   chk("R1 status", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R3 R4 R7 R9 sweep over prescale, modulo and compare position
    for (int ps = 0; ps < 4; ps++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          int modv, cmpv, len, steps;
          modv = (mi != 0) ? 6 : 3;
          cmpv = (ci != 0) ? modv : 1;
          len  = (2 * (modv + 1)) << ps;
          wr(A_CTRL, 32'h0);
          wr(A_CTRL, 32'h80);
          wr(A_MOD, modv);
          wr(A_CHVAL, cmpv);
          wr(A_CHCTRL, 32'hD0);
          wr(A_COUNT, 32'hDEAD_BEEF ^ ps);   // R6 any data clears
          wr(A_CTRL, 32'h08 | ps);
          for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            steps = j >> ps;
            rd(A_COUNT, d);
            chk("R3 R4 count", d, steps % (modv + 1));
            chk("R7 R9 irq", {31'd0, irq}, (steps >= cmpv) ? 32'd1 : 32'd0);
          end
          rd(A_CTRL, d);
          chk("R5 tof after wrap", d[7], 1'b1);
        end
      end
    end

    // R9 gating by enable, R8 mirror and clear from status
    wr(A_CTRL, 32'h0);
    wr(A_CHCTRL, 32'h10);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    rd(A_CHCTRL, d); chk("R9 flag kept", d, 32'h0000_0090);
    rd(A_STAT, d);   chk("R8 status mirror", d, 32'd1);
    wr(A_CHCTRL, 32'h50);
    chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);   chk("R8 zero write keeps", d, 32'd1);
    wr(A_STAT, 32'h1);
    rd(A_CHCTRL, d); chk("R8 cleared via status", d, 32'h0000_0050);
    chk("R8 irq low", {31'd0, irq}, 32'd0);

    // R2 counter holds when clock select is not 01
    wr(A_MOD, 32'hFFFF);
    wr(A_CTRL, 32'h08);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h03);
    rd(A_COUNT, held);
    repeat (20) @(negedge clk);
    rd(A_COUNT, d); chk("R2 held sel 00", d, held);
    wr(A_CTRL, 32'h10);
    repeat (20) @(negedge clk);
    rd(A_COUNT, d); chk("R2 held sel 10", d, held);

    // R7 non-compare mode never flags
    wr(A_MOD, 32'd6);
    wr(A_CHVAL, 32'd2);
    wr(A_CHCTRL, 32'hC8);
    wr(A_COUNT, 32'd0);
    wr(A_CTRL, 32'h08);
    repeat (20) @(negedge clk);
    rd(A_CHCTRL, d); chk("R7 other mode flag", d[7], 1'b0);
    chk("R7 other mode irq", {31'd0, irq}, 32'd0);

    // R10 match and clear on the same edge
    wr(A_CTRL, 32'h0);
    wr(A_CHCTRL, 32'hD0);
    wr(A_MOD, 32'd20);
    wr(A_CHVAL, 32'd5);
    wr(A_CTRL, 32'h08);
    wr(A_COUNT, 32'h1234);
    repeat (4) @(negedge clk);
    wr(A_CHCTRL, 32'hD0);
    rd(A_CHCTRL, d); chk("R10 set beats clear", d[7], 1'b1);
    rd(A_COUNT, d);  chk("R10 count at match", d, 32'd5);
    wr(A_CHCTRL, 32'hD0);
    rd(A_CHCTRL, d); chk("R8 plain clear", d[7], 1'b0);

    // R4 R5 free-running wrap at full width
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h80);
    wr(A_MOD, 32'hFFFF);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h08);
    repeat (65535) @(negedge clk);
    rd(A_COUNT, d); chk("R4 full count", d, 32'h0000_FFFF);
    rd(A_CTRL, d);  chk("R5 no tof yet", d[7], 1'b0);
    @(negedge clk);
    rd(A_COUNT, d); chk("R4 free wrap", d, 32'd0);
    rd(A_CTRL, d);  chk("R5 tof on wrap", d[7], 1'b1);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, d);  chk("R5 zero write keeps tof", d[7], 1'b1);
    wr(A_CTRL, 32'h80);
    rd(A_CTRL, d);  chk("R5 tof cleared", d[7], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule